// File: doc/BRIEF.md
# Nesting Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents one interrupt request line together with the handler address of the source that should run next. Each source carries an enable bit, a software trigger bit, a 4-bit urgency value, a 32-bit handler address and a stored class bit. Software reaches all of this through a simple word-wide register bus with separate read and write strobes.

Service is nested. Reading the current-vector register hands the winning source to software and marks its urgency level as being serviced. While a level is in service, only strictly more urgent sources raise the request line. Any write to the current-vector register closes the most recently opened level and returns to the one below it. A 16-bit level mask can silence whole urgency levels at once.

Top module: `nest_vic`

## Requirements
- R1: After reset the request line is low, the enable, trigger and class registers read 0, the level mask reads 0xFFFF, every urgency reads 0xF and every handler address and the fallback address read 0.
- R2: Writing the enable-set register (0x010) sets exactly the enable bits written as 1; writing the enable-clear register (0x014) clears exactly those bits; reading 0x010 returns the enable bits.
- R3: Writing 0x018 sets and writing 0x01C clears software trigger bits, one per 1 bit written; reading 0x018 returns them; a source requests when (input high or trigger bit set) and its enable bit is set.
- R4: A source whose input is high while its enable bit is clear stays quiet and is delivered as soon as its enable bit is set.
- R5: A read of 0xF00 while a source is deliverable returns that source's handler address (written at 0x100 + 4*n) and marks its urgency level as in service.
- R6: Urgency is set at 0x200 + 4*n (bits 3:0); the numerically lowest urgency wins, and on a tie the lower source number wins.
- R7: With a level in service, only a source whose urgency is numerically lower than the most urgent level in service is delivered; equal or higher values wait.
- R8: Any write to 0xF00 ends the most urgent level in service, so the level below becomes the current one.
- R9: Clearing bit k of the level mask (0x024, bits 15:0) stops every source of urgency k from being delivered.
- R10: A read of 0xF00 with nothing deliverable returns the fallback address (0xF04) and changes no service state.
- R11: The class register (0x00C) reads back the last value written, bit by bit per source.
- R12: The request line and the vector output reflect the arbitration result one clock later; the vector output shows the fallback address when nothing is deliverable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vect_o | output | 32 | Handler address of the current winner, or the fallback address |

## Verification
The arbitration is tried with a lone source, with two sources of equal urgency (which exposes the tie rule by source number) and with sources of differing urgency (which exposes urgency ordering). Nesting is tried by opening a low-urgency service, presenting an equal-urgency source that must wait and then a more urgent one that must pre-empt, and closing the levels one at a time so a wrong closing order shows up as a wrong request. The mask, the software triggers and the late enable are each tried against a source that would otherwise win, so that any leak shows on the request line or the vector.

// File: rtl/nest_vic_pkg.sv
// Package: shared sizes and register offsets of the nesting interrupt controller.
// Assumes word-aligned byte addresses on a 12-bit bus.
package nest_vic_pkg;
    localparam int NSRC   = 32;
    localparam int PRIO_W = 4;
    localparam int NLVL   = 1 << PRIO_W;
    localparam int LVL_W  = PRIO_W + 1;
    localparam int IDX_W  = $clog2(NSRC);

    localparam logic [11:0] OFF_STATUS = 12'h000;
    localparam logic [11:0] OFF_RAW    = 12'h008;
    localparam logic [11:0] OFF_CLASS  = 12'h00C;
    localparam logic [11:0] OFF_ENSET  = 12'h010;
    localparam logic [11:0] OFF_ENCLR  = 12'h014;
    localparam logic [11:0] OFF_SWSET  = 12'h018;
    localparam logic [11:0] OFF_SWCLR  = 12'h01C;
    localparam logic [11:0] OFF_LMASK  = 12'h024;
    localparam logic [11:0] OFF_CURVEC = 12'hF00;
    localparam logic [11:0] OFF_DEFVEC = 12'hF04;
    localparam logic [3:0]  PAGE_VEC   = 4'h1;
    localparam logic [3:0]  PAGE_PRIO  = 4'h2;
endpackage

// File: rtl/nest_vic_arb.sv
// Module: picks the deliverable source with the lowest urgency value.
// Assumes: a source is a candidate when requesting, its level is unmasked and
// its urgency is numerically below the current service level (NLVL = idle).
// Ties go to the lower source number. Purely combinational.
module nest_vic_arb #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    localparam int NLVL  = 1 << PRIO_W,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             req_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [NLVL-1:0]             lmask_i,
    input  logic [PRIO_W:0]             cur_lvl_i,
    output logic                        win_valid_o,
    output logic [IDX_W-1:0]            win_idx_o,
    output logic [PRIO_W-1:0]           win_prio_o
);
    logic [NSRC-1:0] cand;

    // Candidate filter per source.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            cand[i] = req_i[i] && lmask_i[prio_i[i]] &&
                      ({1'b0, prio_i[i]} < cur_lvl_i);
        end
    end

    // Linear search: strict compare keeps the lower index on a tie.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!win_valid_o || prio_i[i] < win_prio_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/nest_vic_svc.sv
// Module: stack of urgency levels in service, kept as one bit per level.
// Assumes: nesting only ever opens a more urgent level, so the lowest set bit
// is both the current level and the last one opened. Push and pop never
// coincide (the top gives reads and writes separate strobes).
module nest_vic_svc #(
    parameter int PRIO_W = 4,
    localparam int NLVL  = 1 << PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_lvl_i,
    input  logic              pop_i,
    output logic [NLVL-1:0]   svc_o,
    output logic [PRIO_W:0]   cur_lvl_o
);
    logic [NLVL-1:0] svc_q;

    // Open a level on acknowledge, close the most urgent one on end of service.
    always_ff @(posedge clk) begin
        if (!rst_n)      svc_q <= '0;
        else if (push_i) svc_q <= svc_q | (NLVL'(1) << push_lvl_i);
        else if (pop_i)  svc_q <= svc_q & (svc_q - NLVL'(1));
    end

    // Current level: lowest set bit, or NLVL when nothing is in service.
    always_comb begin
        cur_lvl_o = (PRIO_W+1)'(NLVL);
        for (int k = NLVL - 1; k >= 0; k--) begin
            if (svc_q[k]) cur_lvl_o = (PRIO_W+1)'(k);
        end
    end

    assign svc_o = svc_q;

    // R8: ending service closes exactly one level.
    p_pop_closes_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && svc_q != '0) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R5: an acknowledge leaves its level marked.
    p_push_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> svc_q[$past(push_lvl_i)]);
endmodule

// File: rtl/nest_vic.sv
// Module: top of the nesting vectored interrupt controller.
// Holds the per-source registers, decodes the register bus, and connects the
// arbiter and the service stack. Read data is registered (one cycle latency);
// request and vector outputs are registered from the arbitration result.
module nest_vic
    import nest_vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_i,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [11:0] bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic [31:0] vect_o
);
    logic [NSRC-1:0]             en_q, sw_q, cls_q;
    logic [NLVL-1:0]             lmask_q;
    logic [NSRC-1:0][31:0]       vec_q;
    logic [NSRC-1:0][PRIO_W-1:0] prio_q;
    logic [31:0]                 defv_q;

    logic [NSRC-1:0]   req;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic [NLVL-1:0]   svc;
    logic [PRIO_W:0]   cur_lvl;
    logic              hit_cur, ack, fin, in_vec, in_prio;
    logic [IDX_W-1:0]  slot;
    logic [31:0]       rd_mux;

    assign req     = (src_i | sw_q) & en_q;
    assign hit_cur = (bus_addr_i == OFF_CURVEC);
    assign ack     = bus_rd_i && !bus_wr_i && hit_cur && win_valid;
    assign fin     = bus_wr_i && hit_cur;
    assign in_vec  = (bus_addr_i[11:8] == PAGE_VEC)  && !bus_addr_i[7];
    assign in_prio = (bus_addr_i[11:8] == PAGE_PRIO) && !bus_addr_i[7];
    assign slot    = bus_addr_i[IDX_W+1:2];

    nest_vic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .req_i(req), .prio_i(prio_q), .lmask_i(lmask_q), .cur_lvl_i(cur_lvl),
        .win_valid_o(win_valid), .win_idx_o(win_idx), .win_prio_o(win_prio)
    );

    nest_vic_svc #(.PRIO_W(PRIO_W)) u_svc (
        .clk(clk), .rst_n(rst_n), .push_i(ack), .push_lvl_i(win_prio),
        .pop_i(fin), .svc_o(svc), .cur_lvl_o(cur_lvl)
    );

    // Control-register writes: set/clear pairs act only on bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            sw_q    <= '0;
            cls_q   <= '0;
            lmask_q <= '1;
            defv_q  <= '0;
        end else if (bus_wr_i) begin
            unique case (bus_addr_i)
                OFF_ENSET:  en_q    <= en_q | bus_wdata_i;
                OFF_ENCLR:  en_q    <= en_q & ~bus_wdata_i;
                OFF_SWSET:  sw_q    <= sw_q | bus_wdata_i;
                OFF_SWCLR:  sw_q    <= sw_q & ~bus_wdata_i;
                OFF_CLASS:  cls_q   <= bus_wdata_i;
                OFF_LMASK:  lmask_q <= bus_wdata_i[NLVL-1:0];
                OFF_DEFVEC: defv_q  <= bus_wdata_i;
                default: ;
            endcase
        end
    end

    // Per-source handler address and urgency tables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            prio_q <= '1;
        end else if (bus_wr_i) begin
            if (in_vec)  vec_q[slot]  <= bus_wdata_i;
            if (in_prio) prio_q[slot] <= bus_wdata_i[PRIO_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        if (in_vec)       rd_mux = vec_q[slot];
        else if (in_prio) rd_mux = 32'(prio_q[slot]);
        else begin
            unique case (bus_addr_i)
                OFF_STATUS: rd_mux = req;
                OFF_RAW:    rd_mux = src_i;
                OFF_CLASS:  rd_mux = cls_q;
                OFF_ENSET:  rd_mux = en_q;
                OFF_SWSET:  rd_mux = sw_q;
                OFF_LMASK:  rd_mux = 32'(lmask_q);
                OFF_CURVEC: rd_mux = win_valid ? vec_q[win_idx] : defv_q;
                OFF_DEFVEC: rd_mux = defv_q;
                default:    rd_mux = '0;
            endcase
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_mux;
    end

    // Registered request line and vector output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            vect_o <= '0;
        end else begin
            irq_o  <= win_valid;
            vect_o <= win_valid ? vec_q[win_idx] : defv_q;
        end
    end

    // R7: a winner is always strictly more urgent than the level in service.
    p_win_beats_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ({1'b0, win_prio} < cur_lvl));

    // R9: a winner never sits on a masked level.
    p_win_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> lmask_q[win_prio]);

    // R10: an acknowledge with nothing deliverable leaves service state alone.
    p_idle_ack_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && hit_cur && !win_valid) |=> $stable(svc));

    // R6: the winner is requesting and enabled.
    p_win_requests_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (req[win_idx] && en_q[win_idx]));
endmodule

// File: tb/nest_vic_tb.sv
// Bench: scoreboard of expected read data; the driver queues an expected word
// per read, the monitor pops and compares one cycle after the strobe.
module nest_vic_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, vect;
    logic        irq;

    int n_chk = 0, n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    nest_vic u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .vect_o(vect)
    );

    function automatic logic [31:0] hv(int n);
        return 32'h0000_1000 + 32'(n) * 32'h10;
    endfunction

    // Monitor: compare read data against the scoreboard head.
    always @(posedge clk) begin
        if (rd && rst_n) begin
            #1;
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (rdata !== e) begin
                    n_err++;
                    $display("FAIL %s: read actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic check_out(input logic ei, input logic [31:0] ev, input string t);
        repeat (3) @(negedge clk);
        n_chk++;
        if (irq !== ei || (ei && vect !== ev)) begin
            n_err++;
            $display("FAIL %s: irq/vect actual %b/%h expected %b/%h", t, irq, vect, ei, ev);
        end
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                // R1 reset state
                check_out(1'b0, 32'h0, "R1 irq");
                bus_read(12'h010, 32'h0, "R1 enable");
                bus_read(12'h024, 32'h0000_FFFF, "R1 mask");
                bus_read(12'h20C, 32'hF, "R1 urgency");
                bus_read(12'h104, 32'h0, "R1 vector");
                for (int i = 0; i < 12; i++) bus_write(12'h100 + 12'(4*i), hv(i));
                bus_write(12'hF04, 32'hDEAD_0000);
                // R10 empty acknowledge
                bus_read(12'hF00, 32'hDEAD_0000, "R10 default");
                // R2 set/clear
                bus_write(12'h010, 32'h0000_00F0);
                bus_write(12'h014, 32'h0000_0030);
                bus_read(12'h010, 32'h0000_00C0, "R2 enable bits");
                // R4 late enable
                src[9] = 1'b1;
                check_out(1'b0, 32'h0, "R4 disabled quiet");
                bus_write(12'h010, 32'h0000_0200);
                check_out(1'b1, hv(9), "R4 delivered");
                // R5 acknowledge
                bus_read(12'hF00, hv(9), "R5 ack vector");
                check_out(1'b0, 32'h0, "R5 level blocks itself");
                // R7 equal waits
                src[6] = 1'b1;
                check_out(1'b0, 32'h0, "R7 equal waits");
                // R7 preempt
                bus_write(12'h21C, 32'h3);
                src[7] = 1'b1;
                check_out(1'b1, hv(7), "R7 preempt");
                bus_read(12'hF00, hv(7), "R7 nested ack");
                src[7] = 1'b0;
                // R8 end of service one level at a time
                bus_write(12'hF00, 32'h0);
                check_out(1'b0, 32'h0, "R8 inner closed, outer holds");
                bus_write(12'hF00, 32'h0);
                // R6 tie: 6 and 9 both urgency 15
                check_out(1'b1, hv(6), "R6 tie lower index");
                bus_write(12'h224, 32'h2);
                check_out(1'b1, hv(9), "R6 lower urgency wins");
                // R9 mask level 2
                bus_write(12'h024, 32'h0000_FFFB);
                check_out(1'b1, hv(6), "R9 masked level");
                bus_write(12'h024, 32'h0000_FFFF);
                // R3 software trigger
                bus_write(12'h010, 32'h0000_0002);
                bus_write(12'h204, 32'h0);
                bus_write(12'h018, 32'h0000_0002);
                bus_read(12'h018, 32'h0000_0002, "R3 trigger bits");
                check_out(1'b1, hv(1), "R3 soft delivered");
                bus_write(12'h01C, 32'h0000_0002);
                check_out(1'b1, hv(9), "R3 soft cleared");
                // R11 class storage
                bus_write(12'h00C, 32'h0000_0005);
                bus_read(12'h00C, 32'h0000_0005, "R11 class");
                // R10 no state change: empty ack then low-urgency source delivered
                src = '0;
                bus_read(12'hF00, 32'hDEAD_0000, "R10 default again");
                src[6] = 1'b1;
                check_out(1'b1, hv(6), "R10 stack untouched");
                // R12 vector output default when idle
                src = '0;
                repeat (3) @(negedge clk);
                n_chk++;
                if (irq !== 1'b0 || vect !== 32'hDEAD_0000) begin
                    n_err++;
                    $display("FAIL R12 idle vect: actual %b/%h expected 0/dead0000", irq, vect);
                end
                repeat (3) @(negedge clk);
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule